// File: doc/BRIEF.md
# Scanline interrupt down-counter

This block raises an interrupt request to the CPU after a programmed number of rendered video lines. Software sets a reload value, can force the counter to zero, and switches the interrupt on or off through four write strobes decoded from a 16-bit CPU write address. The video side supplies the current line number, the current dot position and the background and sprite rendering flags. The block counts one step per qualifying line.

A line counts once, when the dot position equals 260, on a line outside the blanking range 240 to 260, and with at least one rendering flag set. A step taken with the counter at zero loads the reload value. A step taken with a nonzero counter decrements it. A decrement that reaches zero with the interrupt enabled sets the request. The request is a level and stays high until a disable write clears it. Typical use is a mid-frame split: program N, clear, enable, and take the interrupt after N+1 counted lines.

Top module: `scanline_irq_counter`

## Requirements
- R1: A synchronous active-high reset clears the reload value, the counter, the enable flag and the request, so `irq_req` is 0 after reset.
- R2: A write whose address bits [15:13] are 3'b110 and whose bit 0 is 0 stores `wr_data` as the reload value.
- R3: A write whose address bits [15:13] are 3'b110 and whose bit 0 is 1 sets the counter to zero.
- R4: The counter steps only when `dot_pos` equals 260. It steps once per contiguous stretch of such cycles, however long `dot_pos` is held there.
- R5: No step occurs while `line_num` is between 240 and 260 inclusive.
- R6: No step occurs while `bg_enable` and `spr_enable` are both 0. Either flag alone permits a step.
- R7: A step with the counter at zero loads the reload value and never raises the request.
- R8: A step that decrements the counter from 1 to 0 while the interrupt is enabled sets `irq_req`. The request then holds through later steps.
- R9: A decrement to zero while the interrupt is disabled leaves `irq_req` at 0.
- R10: A write with address bits [15:13] = 3'b111 and bit 0 = 0 disables the interrupt and clears `irq_req`. The same region with bit 0 = 1 enables the interrupt.
- R11: Writes outside address regions 3'b110 and 3'b111 change neither the reload value, the counter nor the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_num | input | 9 | Current video line number |
| dot_pos | input | 9 | Current dot position within the line |
| bg_enable | input | 1 | Background rendering enabled |
| spr_enable | input | 1 | Sprite rendering enabled |
| irq_req | output | 1 | Registered level interrupt request |

## Verification
Every cycle, the assertions check four things about the internal step pulse: it lasts one cycle, and it follows only a dot of 260, a line outside the blanking range and an active rendering flag. They also check that the request is cleared after reset and after a disable write, that it holds otherwise, and that it rises only right after a step. How many steps pass before the request rises depends on the counter and reload contents, which only the bench scenarios expose. Those scenarios cover the reload-on-zero behaviour, the effect of clear and enable writes, and the writes to foreign addresses that must change nothing.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;

  // Decoded CPU write strobes, at most one high per cycle
  typedef struct packed {
    logic set_reload;
    logic zero_count;
    logic irq_off;
    logic irq_on;
  } wr_strobe_t;

  localparam logic [2:0] REGION_COUNT = 3'b110;
  localparam logic [2:0] REGION_IRQ   = 3'b111;

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output wr_strobe_t        strobe
);
  localparam int REGION_LSB = ADDR_W - 3;

  logic [2:0] region;
  logic       odd;

  assign region = wr_addr[ADDR_W-1:REGION_LSB];
  assign odd    = wr_addr[0];

  always_comb begin
    strobe = '0;
    if (wr_en) begin
      if (region == REGION_COUNT) begin
        strobe.set_reload = !odd;
        strobe.zero_count = odd;
      end else if (region == REGION_IRQ) begin
        strobe.irq_off = !odd;
        strobe.irq_on  = odd;
      end
    end
  end
endmodule

// File: rtl/line_tick_gen.sv
module line_tick_gen #(
  parameter int LINE_W      = 9,
  parameter int DOT_W       = 9,
  parameter int TICK_DOT    = 260,
  parameter int BLANK_FIRST = 240,
  parameter int BLANK_LAST  = 260
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] line_num,
  input  logic [DOT_W-1:0]  dot_pos,
  input  logic              bg_enable,
  input  logic              spr_enable,
  output logic              tick
);
  localparam logic [DOT_W-1:0]  DOT_MATCH = DOT_W'(TICK_DOT);
  localparam logic [LINE_W-1:0] LINE_LO   = LINE_W'(BLANK_FIRST);
  localparam logic [LINE_W-1:0] LINE_HI   = LINE_W'(BLANK_LAST);

  logic in_blank;
  logic qualify;
  logic qualify_q;

  assign in_blank = (line_num >= LINE_LO) && (line_num <= LINE_HI);
  assign qualify  = (dot_pos == DOT_MATCH) && !in_blank && (bg_enable || spr_enable);

  // Edge detect: a held qualifier yields a single pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      qualify_q <= 1'b0;
      tick      <= 1'b0;
    end else begin
      qualify_q <= qualify;
      tick      <= qualify && !qualify_q;
    end
  end
endmodule

// File: rtl/line_down_counter.sv
module line_down_counter
  import scanline_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_strobe_t        strobe,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic              irq_req
);
  localparam logic [DATA_W-1:0] ZERO = '0;
  localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);

  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] count_q;
  logic              enable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      count_q  <= '0;
      enable_q <= 1'b0;
      irq_req  <= 1'b0;
    end else begin
      if (strobe.set_reload) reload_q <= wr_data;

      // A clear write wins over a step in the same cycle
      if (strobe.zero_count)    count_q <= '0;
      else if (tick) begin
        if (count_q == ZERO)    count_q <= reload_q;
        else                    count_q <= count_q - ONE;
      end

      if (strobe.irq_off)       enable_q <= 1'b0;
      else if (strobe.irq_on)   enable_q <= 1'b1;

      if (strobe.irq_off)       irq_req <= 1'b0;
      else if (tick && enable_q && count_q == ONE && !strobe.zero_count)
                                irq_req <= 1'b1;
    end
  end
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int LINE_W      = 9,
  parameter int DOT_W       = 9,
  parameter int TICK_DOT    = 260,
  parameter int BLANK_FIRST = 240,
  parameter int BLANK_LAST  = 260
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LINE_W-1:0] line_num,
  input  logic [DOT_W-1:0]  dot_pos,
  input  logic              bg_enable,
  input  logic              spr_enable,
  output logic              irq_req
);
  wr_strobe_t strobe;
  logic       tick_pulse;

  irq_wr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .strobe  (strobe)
  );

  line_tick_gen #(
    .LINE_W(LINE_W), .DOT_W(DOT_W), .TICK_DOT(TICK_DOT),
    .BLANK_FIRST(BLANK_FIRST), .BLANK_LAST(BLANK_LAST)
  ) u_tick (
    .clk        (clk),
    .rst        (rst),
    .line_num   (line_num),
    .dot_pos    (dot_pos),
    .bg_enable  (bg_enable),
    .spr_enable (spr_enable),
    .tick       (tick_pulse)
  );

  line_down_counter #(.DATA_W(DATA_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .wr_data (wr_data),
    .tick    (tick_pulse),
    .irq_req (irq_req)
  );
endmodule

// File: rtl/scanline_irq_checker.sv
module scanline_irq_checker #(
  parameter int LINE_W      = 9,
  parameter int DOT_W       = 9,
  parameter int TICK_DOT    = 260,
  parameter int BLANK_FIRST = 240,
  parameter int BLANK_LAST  = 260
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              irq_off,
  input logic [LINE_W-1:0] line_num,
  input logic [DOT_W-1:0]  dot_pos,
  input logic              bg_enable,
  input logic              spr_enable,
  input logic              irq_req
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  always_ff @(posedge clk) begin
    if (rst_seen === 1'b1) assert_reset_clears_R1: assert (!irq_req);
  end

  assert_tick_single_R4: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  assert_tick_dot_R4: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(dot_pos) == DOT_W'(TICK_DOT));
  assert_tick_blank_R5: assert property (@(posedge clk) disable iff (rst)
    tick |-> ($past(line_num) < LINE_W'(BLANK_FIRST) || $past(line_num) > LINE_W'(BLANK_LAST)));
  assert_tick_render_R6: assert property (@(posedge clk) disable iff (rst)
    tick |-> ($past(bg_enable) || $past(spr_enable)));
  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_off) |=> irq_req);
  assert_irq_after_tick_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(tick));
  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (rst)
    irq_off |=> !irq_req);
endmodule

bind scanline_irq_counter scanline_irq_checker #(
  .LINE_W(LINE_W), .DOT_W(DOT_W), .TICK_DOT(TICK_DOT),
  .BLANK_FIRST(BLANK_FIRST), .BLANK_LAST(BLANK_LAST)
) u_checker (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick_pulse),
  .irq_off    (strobe.irq_off),
  .line_num   (line_num),
  .dot_pos    (dot_pos),
  .bg_enable  (bg_enable),
  .spr_enable (spr_enable),
  .irq_req    (irq_req)
);

// File: tb/test_scanline_irq_counter.sv
module test_scanline_irq_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [8:0]  line_num = '0;
  logic [8:0]  dot_pos = '0;
  logic        bg_enable = 1'b1;
  logic        spr_enable = 1'b1;
  logic        irq_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model state, built from the requirements
  logic       m_qual_q, m_tick, m_en, m_irq;
  logic [7:0] m_reload, m_cnt;

  always #5 clk = ~clk;

  scanline_irq_counter i_scanline_irq_counter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .line_num(line_num), .dot_pos(dot_pos), .bg_enable(bg_enable),
    .spr_enable(spr_enable), .irq_req(irq_req)
  );

  function automatic logic qualifies(logic [8:0] ln, logic [8:0] dp, logic bg, logic sp);
    return (dp == 9'd260) && !(ln >= 9'd240 && ln <= 9'd260) && (bg || sp);
  endfunction

  always @(posedge clk) begin
    logic q, n_tick, rl, cl, off, on;
    logic [7:0] n_cnt;
    logic n_irq;
    if (rst) begin
      m_qual_q = 0; m_tick = 0; m_en = 0; m_irq = 0; m_reload = 0; m_cnt = 0;
    end else begin
      q   = qualifies(line_num, dot_pos, bg_enable, spr_enable);
      rl  = wr_en && wr_addr[15:13] == 3'b110 && !wr_addr[0];
      cl  = wr_en && wr_addr[15:13] == 3'b110 &&  wr_addr[0];
      off = wr_en && wr_addr[15:13] == 3'b111 && !wr_addr[0];
      on  = wr_en && wr_addr[15:13] == 3'b111 &&  wr_addr[0];
      n_tick = q && !m_qual_q;
      n_cnt = m_cnt;
      n_irq = m_irq;
      if (cl) n_cnt = 0;
      else if (m_tick) n_cnt = (m_cnt == 0) ? m_reload : m_cnt - 8'd1;
      if (off) n_irq = 0;
      else if (m_tick && !cl && m_en && m_cnt == 8'd1) n_irq = 1;
      if (off) m_en = 0; else if (on) m_en = 1;
      if (rl) m_reload = wr_data;
      m_cnt = n_cnt; m_irq = n_irq; m_qual_q = q; m_tick = n_tick;
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irq_req=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cpu_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // One video line: dot held at 260 for three cycles, then away
  task automatic line_pass(logic [8:0] ln, int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_num = ln; dot_pos = 9'd260;
      repeat (3) @(negedge clk);
      dot_pos = 9'd0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic restart(logic [7:0] n);
    cpu_write(16'hE000, 8'h00);
    cpu_write(16'hC000, n);
    cpu_write(16'hC001, 8'h00);
    cpu_write(16'hE001, 8'h00);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset", irq_req, 1'b0);

    // R2/R7/R8/R4: reload 3, four single-count lines reach zero
    restart(8'd3);
    line_pass(9'd10, 3);
    check("R4 one step per held dot", irq_req, 1'b0);
    line_pass(9'd11);
    check("R8 fire on decrement to zero (R2 reload)", irq_req, 1'b1);
    line_pass(9'd12, 2);
    check("R8 request holds", irq_req, 1'b1);

    // R10/R3/R7
    cpu_write(16'hE000, 8'h00);
    check("R10 disable clears request", irq_req, 1'b0);
    cpu_write(16'hC001, 8'h00);
    cpu_write(16'hE001, 8'h00);
    line_pass(9'd20, 3);
    check("R3 clear then R7 load without request", irq_req, 1'b0);
    line_pass(9'd21);
    check("R10 enable arms request", irq_req, 1'b1);

    // R5 blanking lines
    restart(8'd3);
    line_pass(9'd240, 4); line_pass(9'd250, 4); line_pass(9'd260, 4);
    check("R5 no step in blanking", irq_req, 1'b0);
    line_pass(9'd239); line_pass(9'd261); line_pass(9'd0);
    check("R5 edges of blanking count", irq_req, 1'b0);
    line_pass(9'd100);
    check("R5 fourth visible step fires", irq_req, 1'b1);

    // R6 rendering flags
    restart(8'd3);
    bg_enable = 0; spr_enable = 0;
    line_pass(9'd30, 6);
    check("R6 no step with rendering off", irq_req, 1'b0);
    spr_enable = 1;
    line_pass(9'd31, 4);
    check("R6 sprite flag alone counts", irq_req, 1'b1);
    restart(8'd3);
    bg_enable = 1; spr_enable = 0;
    line_pass(9'd32, 4);
    check("R6 background flag alone counts", irq_req, 1'b1);
    spr_enable = 1;

    // R9 disabled decrement
    cpu_write(16'hE000, 8'h00);
    cpu_write(16'hC001, 8'h00);
    line_pass(9'd40, 4);
    check("R9 no request while disabled", irq_req, 1'b0);
    cpu_write(16'hE001, 8'h00);
    line_pass(9'd41, 3);
    check("R9 enable later, not yet zero", irq_req, 1'b0);
    line_pass(9'd42);
    check("R9 enabled decrement fires", irq_req, 1'b1);

    // R11 foreign writes
    restart(8'd3);
    cpu_write(16'hA000, 8'h01);
    cpu_write(16'h8000, 8'h01);
    line_pass(9'd50);
    cpu_write(16'h4001, 8'h00);
    cpu_write(16'hA001, 8'h00);
    cpu_write(16'h6001, 8'h00);
    line_pass(9'd51, 2);
    check("R11 foreign writes leave counter and reload", irq_req, 1'b0);
    line_pass(9'd52);
    check("R11 count completes unchanged", irq_req, 1'b1);
    cpu_write(16'h8001, 8'h00);
    cpu_write(16'hA000, 8'h00);
    check("R11 foreign writes leave request", irq_req, 1'b1);
    cpu_write(16'hE000, 8'h00);

    // Random phase against the model (R2..R11)
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      check("R8 random vs model", irq_req, m_irq);
      line_num   = ($urandom_range(0, 3) == 0) ? 9'($urandom_range(238, 262)) : 9'($urandom_range(0, 239));
      dot_pos    = ($urandom_range(0, 2) == 0) ? 9'd260 : 9'($urandom_range(0, 340));
      bg_enable  = ($urandom_range(0, 5) != 0);
      spr_enable = ($urandom_range(0, 5) != 0);
      wr_en      = ($urandom_range(0, 9) == 0);
      case ($urandom_range(0, 6))
        0: wr_addr = 16'hC000;
        1: wr_addr = 16'hD001;
        2: wr_addr = 16'hE000;
        3: wr_addr = 16'hF001;
        4: wr_addr = 16'hA000;
        5: wr_addr = 16'h8001;
        default: wr_addr = 16'($urandom_range(0, 16'hFFFF));
      endcase
      wr_data = 8'($urandom_range(0, 4));
    end
    wr_en = 0;
    @(negedge clk);
    check("R8 random final", irq_req, m_irq);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule